// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 40-bit physical address by reading a two-level translation structure held in ordinary memory. A requester presents the address with two qualifiers: whether the access is a write and whether it comes from user mode. The walker takes the directory base from a control-register value and reads the directory entry through a single 32-bit memory port. If that entry points to a second-level table, the walker then reads the table entry. It returns either a physical address or a fault together with a cause code.

Directory entries may map a 4MiB region directly. Such an entry contributes eight extra high-order physical address bits and has one bit that must be zero. The walker keeps the usage flags up to date. It sets the accessed flag in every entry it passes, and it sets the dirty flag in the final entry when the access is a write. It writes an entry back to memory only when one of those flags actually changes. All write-backs are finished before the response appears. Only one walk is in flight at a time.

Top module: `xlat_walker`

## Requirements
- R1: The directory entry is read from {root_ctrl_i[31:12], 12'h000} + 4*vaddr[31:22]. A second-level entry is read from {dir_entry[31:12], 12'h000} + 4*vaddr[21:12]. The low twelve bits of root_ctrl_i have no effect.
- R2: Entry bit 0 is the present flag. If it is 0 at either level, the walk ends with rsp_fault_o=1 and rsp_cause_o=0. This check has priority over every other check.
- R3: Entry bit 1 allows writes. A write that meets a 0 in this bit at either level faults with cause 1.
- R4: Entry bit 2 allows user access. A user access that meets a 0 in this bit at either level faults with cause 2. Cause 1 has priority over cause 2.
- R5: A directory entry with bit 7 set maps a 4MiB page. The physical address is {entry[20:13], entry[31:22], vaddr[21:0]}, and no second-level read is made.
- R6: A 4MiB directory entry with bit 21 set faults with cause 3. This check comes after the present check and before the write and user checks.
- R7: For a 4KiB page, the physical address is {8'h00, table_entry[31:12], vaddr[11:0]}.
- R8: Bit 5 (accessed) is set in every entry that passes its checks. Bit 6 (dirty) is set in the final entry of a write. An entry is written back only if its value changes. The entry at the faulting level is never written.
- R9: Every write-back completes before rsp_valid_o rises. The memory port is idle while a response is pending.
- R10: req_ready_o is high only when no walk is in progress. A response holds rsp_valid_o and its data stable until rsp_ready_i is seen high.
- R11: During reset and after it, the walker is idle: req_ready_o=1, rsp_valid_o=0, mem_req_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Walker can accept a request |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_write_i | input | 1 | Access is a write |
| req_user_i | input | 1 | Access comes from user mode |
| root_ctrl_i | input | 32 | Control register holding the directory base in bits 31:12 |
| rsp_valid_o | output | 1 | Response available |
| rsp_ready_i | input | 1 | Requester takes the response |
| rsp_fault_o | output | 1 | Walk ended in a fault |
| rsp_cause_o | output | 2 | Fault cause: 0 not present, 1 write, 2 user, 3 reserved bit |
| rsp_paddr_o | output | 40 | Translated physical address |
| mem_req_o | output | 1 | Memory access request, held until acknowledged |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 32 | Byte address of the entry |
| mem_wdata_o | output | 32 | Entry value to write back |
| mem_ack_i | input | 1 | Memory completes the access; read data valid |
| mem_rdata_i | input | 32 | Entry value read |

## Verification
A corrupted walk state shows up at the ports within a single memory transaction. Depending on the fault, the memory address is wrong, an unexpected write appears, or a write-back is missing. Each of these is visible either in the entry value left in memory or in the response. A wrong fault priority or address composition appears in the very next response. Stuck handshake state shows up as a response that drops early or a request accepted mid-walk.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned BIT_PRES  = 0;
  localparam int unsigned BIT_WRT   = 1;
  localparam int unsigned BIT_USR   = 2;
  localparam int unsigned BIT_ACC   = 5;
  localparam int unsigned BIT_DIRTY = 6;
  localparam int unsigned BIT_BIG   = 7;
  localparam int unsigned BIT_RSV   = 21;

  typedef enum logic [1:0] {
    CAUSE_NP  = 2'd0,
    CAUSE_WP  = 2'd1,
    CAUSE_UP  = 2'd2,
    CAUSE_RSV = 2'd3
  } cause_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DRD  = 3'd1,
    ST_DWB  = 3'd2,
    ST_TRD  = 3'd3,
    ST_TWB  = 3'd4,
    ST_RSP  = 3'd5
  } walk_st_e;
endpackage

// File: rtl/xlat_rst_sync.sv
module xlat_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/xlat_ent_addr.sv
module xlat_ent_addr #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PAGE_SH   = 12,
  parameter int unsigned IDX_W     = 10,
  parameter int unsigned ENT_BYTES = 4
) (
  input  logic [ADDR_W-PAGE_SH-1:0] base_i,
  input  logic [IDX_W-1:0]          idx_i,
  output logic [ADDR_W-1:0]         addr_o
);
  localparam int unsigned SH    = $clog2(ENT_BYTES);
  localparam int unsigned PAD_W = ADDR_W - IDX_W - SH;

  assign addr_o = {base_i, {PAGE_SH{1'b0}}} + {{PAD_W{1'b0}}, idx_i, {SH{1'b0}}};
endmodule

// File: rtl/xlat_ent_eval.sv
module xlat_ent_eval
  import xlat_pkg::*;
#(
  parameter int unsigned ENT_W = 32
) (
  input  logic [ENT_W-1:0] ent_i,
  input  logic             dir_lvl_i,
  input  logic             wr_i,
  input  logic             usr_i,
  output logic             fault_o,
  output cause_e           cause_o,
  output logic             large_o,
  output logic [ENT_W-1:0] upd_o,
  output logic             chg_o
);
  logic leaf;

  always_comb begin
    large_o = dir_lvl_i & ent_i[BIT_BIG];
    leaf    = ~dir_lvl_i | large_o;
    fault_o = 1'b1;
    cause_o = CAUSE_NP;
    if (!ent_i[BIT_PRES]) begin
      cause_o = CAUSE_NP;
    end else if (large_o && ent_i[BIT_RSV]) begin
      cause_o = CAUSE_RSV;
    end else if (wr_i && !ent_i[BIT_WRT]) begin
      cause_o = CAUSE_WP;
    end else if (usr_i && !ent_i[BIT_USR]) begin
      cause_o = CAUSE_UP;
    end else begin
      fault_o = 1'b0;
    end
    upd_o = ent_i;
    upd_o[BIT_ACC] = 1'b1;
    if (leaf && wr_i) upd_o[BIT_DIRTY] = 1'b1;
    chg_o = (upd_o != ent_i);
  end
endmodule

// File: rtl/xlat_paddr_form.sv
module xlat_paddr_form #(
  parameter int unsigned VA_W    = 32,
  parameter int unsigned PA_W    = 40,
  parameter int unsigned PAGE_SH = 12,
  parameter int unsigned BIG_SH  = 22,
  parameter int unsigned EXT_LO  = 13
) (
  input  logic [VA_W-1:0]   ent_i,
  input  logic [BIG_SH-1:0] voff_i,
  input  logic              large_i,
  output logic [PA_W-1:0]   paddr_o
);
  localparam int unsigned EXT_W = PA_W - VA_W;

  logic [PA_W-1:0] big_pa;
  logic [PA_W-1:0] small_pa;
  logic            unused_lo;

  assign big_pa    = {ent_i[EXT_LO+EXT_W-1:EXT_LO], ent_i[VA_W-1:BIG_SH], voff_i};
  assign small_pa  = {{EXT_W{1'b0}}, ent_i[VA_W-1:PAGE_SH], voff_i[PAGE_SH-1:0]};
  assign paddr_o   = large_i ? big_pa : small_pa;
  assign unused_lo = ^ent_i[EXT_LO-1:0];
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int unsigned VA_W    = 32,
  parameter int unsigned PA_W    = 40,
  parameter int unsigned PAGE_SH = 12,
  parameter int unsigned IDX_W   = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [VA_W-1:0] req_vaddr_i,
  input  logic            req_write_i,
  input  logic            req_user_i,
  input  logic [VA_W-1:0] root_ctrl_i,
  output logic            rsp_valid_o,
  input  logic            rsp_ready_i,
  output logic            rsp_fault_o,
  output logic [1:0]      rsp_cause_o,
  output logic [PA_W-1:0] rsp_paddr_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [VA_W-1:0] mem_addr_o,
  output logic [VA_W-1:0] mem_wdata_o,
  input  logic            mem_ack_i,
  input  logic [VA_W-1:0] mem_rdata_i
);
  localparam int unsigned BIG_SH = PAGE_SH + IDX_W;
  localparam int unsigned BASE_W = VA_W - PAGE_SH;

  logic rst_n_sync;

  walk_st_e           st_q, st_d;
  logic [BIG_SH-1:0]  voff_q;
  logic               wr_q, usr_q, lg_q, flt_q;
  cause_e             cause_q;
  logic [VA_W-1:0]    addr_q, ent_q;
  logic [PA_W-1:0]    pa_q, pa_d;

  logic ld_req, ld_addr, ld_ent, ld_pa, ld_flt;

  logic [BASE_W-1:0]  ag_base;
  logic [IDX_W-1:0]   ag_idx;
  logic [VA_W-1:0]    ag_addr;
  logic               ev_fault, ev_large, ev_chg;
  cause_e             ev_cause;
  logic [VA_W-1:0]    ev_upd;
  logic [PA_W-1:0]    pf_pa;
  logic               unused_root;

  assign unused_root = ^root_ctrl_i[PAGE_SH-1:0];

  xlat_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  always_comb begin
    unique case (st_q)
      ST_IDLE: begin
        ag_base = root_ctrl_i[VA_W-1:PAGE_SH];
        ag_idx  = req_vaddr_i[VA_W-1:BIG_SH];
      end
      ST_DRD: begin
        ag_base = mem_rdata_i[VA_W-1:PAGE_SH];
        ag_idx  = voff_q[BIG_SH-1:PAGE_SH];
      end
      default: begin
        ag_base = ent_q[VA_W-1:PAGE_SH];
        ag_idx  = voff_q[BIG_SH-1:PAGE_SH];
      end
    endcase
  end

  xlat_ent_addr #(
    .ADDR_W(VA_W), .PAGE_SH(PAGE_SH), .IDX_W(IDX_W), .ENT_BYTES(4)
  ) u_addr (
    .base_i (ag_base),
    .idx_i  (ag_idx),
    .addr_o (ag_addr)
  );

  xlat_ent_eval #(.ENT_W(VA_W)) u_eval (
    .ent_i     (mem_rdata_i),
    .dir_lvl_i (st_q == ST_DRD),
    .wr_i      (wr_q),
    .usr_i     (usr_q),
    .fault_o   (ev_fault),
    .cause_o   (ev_cause),
    .large_o   (ev_large),
    .upd_o     (ev_upd),
    .chg_o     (ev_chg)
  );

  xlat_paddr_form #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_SH(PAGE_SH), .BIG_SH(BIG_SH), .EXT_LO(13)
  ) u_pa (
    .ent_i   (mem_rdata_i),
    .voff_i  (voff_q),
    .large_i (ev_large),
    .paddr_o (pf_pa)
  );

  // next-state and load enables
  always_comb begin
    st_d    = st_q;
    ld_req  = 1'b0;
    ld_addr = 1'b0;
    ld_ent  = 1'b0;
    ld_pa   = 1'b0;
    ld_flt  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          ld_req  = 1'b1;
          ld_addr = 1'b1;
          st_d    = ST_DRD;
        end
      end
      ST_DRD: begin
        if (mem_ack_i) begin
          if (ev_fault) begin
            ld_flt = 1'b1;
            st_d   = ST_RSP;
          end else begin
            ld_ent = 1'b1;
            ld_pa  = ev_large;
            if (ev_chg) begin
              st_d = ST_DWB;
            end else if (ev_large) begin
              st_d = ST_RSP;
            end else begin
              ld_addr = 1'b1;
              st_d    = ST_TRD;
            end
          end
        end
      end
      ST_DWB: begin
        if (mem_ack_i) begin
          if (lg_q) begin
            st_d = ST_RSP;
          end else begin
            ld_addr = 1'b1;
            st_d    = ST_TRD;
          end
        end
      end
      ST_TRD: begin
        if (mem_ack_i) begin
          if (ev_fault) begin
            ld_flt = 1'b1;
            st_d   = ST_RSP;
          end else begin
            ld_ent = 1'b1;
            ld_pa  = 1'b1;
            st_d   = ev_chg ? ST_TWB : ST_RSP;
          end
        end
      end
      ST_TWB: begin
        if (mem_ack_i) st_d = ST_RSP;
      end
      ST_RSP: begin
        if (rsp_ready_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign pa_d = ld_req ? '0 : pf_pa;

  // registers
  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      st_q    <= ST_IDLE;
      voff_q  <= '0;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
      lg_q    <= 1'b0;
      flt_q   <= 1'b0;
      cause_q <= CAUSE_NP;
      addr_q  <= '0;
      ent_q   <= '0;
      pa_q    <= '0;
    end else begin
      st_q <= st_d;
      if (ld_req) begin
        voff_q <= req_vaddr_i[BIG_SH-1:0];
        wr_q   <= req_write_i;
        usr_q  <= req_user_i;
      end
      if (ld_addr) addr_q <= ag_addr;
      if (ld_ent) begin
        ent_q <= ev_upd;
        lg_q  <= ev_large;
      end
      if (ld_req || ld_pa) pa_q <= pa_d;
      if (ld_req) begin
        flt_q   <= 1'b0;
        cause_q <= CAUSE_NP;
      end else if (ld_flt) begin
        flt_q   <= 1'b1;
        cause_q <= ev_cause;
      end
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign rsp_valid_o = (st_q == ST_RSP);
  assign rsp_fault_o = flt_q;
  assign rsp_cause_o = cause_q;
  assign rsp_paddr_o = pa_q;
  assign mem_req_o   = (st_q == ST_DRD) || (st_q == ST_DWB) ||
                       (st_q == ST_TRD) || (st_q == ST_TWB);
  assign mem_we_o    = (st_q == ST_DWB) || (st_q == ST_TWB);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = ent_q;
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        rsp_valid_o,
  input logic        rsp_ready_i,
  input logic        rsp_fault_o,
  input logic [1:0]  rsp_cause_o,
  input logic [39:0] rsp_paddr_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic        mem_ack_i
);
  a_r10_rsp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_paddr_o) &&
    $stable(rsp_fault_o) && $stable(rsp_cause_o));

  a_r10_single_walk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);

  a_r9_port_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !mem_req_o);

  a_r1_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  a_r8_wb_marks_accessed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wdata_o[5] && mem_wdata_o[0]);

  a_r10_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) &&
    $stable(mem_we_o) && $stable(mem_wdata_o));
endmodule

bind xlat_walker xlat_walker_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ready_i (rsp_ready_i),
  .rsp_fault_o (rsp_fault_o),
  .rsp_cause_o (rsp_cause_o),
  .rsp_paddr_o (rsp_paddr_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i)
);

// File: tb/xlat_walker_tb.sv
module xlat_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [31:0] root_ctrl = 32'h0000_1FFF;
  logic        rsp_ready = 1'b0;
  logic        req_ready, rsp_valid, rsp_fault;
  logic [1:0]  rsp_cause;
  logic [39:0] rsp_paddr;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

  logic [31:0] mem [4096];
  logic        pl_en = 1'b0;
  logic [31:0] pl_addr = '0, pl_data = '0;
  int          wcount = 0;
  int          total = 0, bad = 0;

  always #10 clk = ~clk;

  xlat_walker u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .req_write_i(req_write), .req_user_i(req_user), .root_ctrl_i(root_ctrl),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_fault_o(rsp_fault),
    .rsp_cause_o(rsp_cause), .rsp_paddr_o(rsp_paddr),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  // memory model: one-cycle acknowledge, bench preload port
  always @(posedge clk) begin
    if (pl_en) mem[pl_addr[13:2]] <= pl_data;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[13:2]] <= mem_wdata;
        wcount <= wcount + 1;
      end else begin
        mem_rdata <= mem[mem_addr[13:2]];
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic        usr;
    logic [31:0] pde;
    logic [31:0] pte;
    logic        flt;
    logic [1:0]  cause;
    logic [39:0] pa;
    logic [31:0] pde_x;
    logic [31:0] pte_x;
    logic [1:0]  nwr;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{32'h0040_3123,1'b0,1'b0,32'h0000_2007,32'h0ABC_D007,1'b0,2'd0,40'h00_0ABC_D123,32'h0000_2027,32'h0ABC_D027,2'd2},
    '{32'h0040_3FFF,1'b1,1'b1,32'h0000_2027,32'h0ABC_D027,1'b0,2'd0,40'h00_0ABC_DFFF,32'h0000_2027,32'h0ABC_D067,2'd1},
    '{32'h0080_0000,1'b0,1'b0,32'h0000_2006,32'h1234_5007,1'b1,2'd0,40'h0,32'h0000_2006,32'h1234_5007,2'd0},
    '{32'h00C0_1000,1'b0,1'b0,32'h0000_2007,32'h5000_0006,1'b1,2'd0,40'h0,32'h0000_2027,32'h5000_0006,2'd1},
    '{32'h0100_2000,1'b1,1'b0,32'h0000_2027,32'h5555_5005,1'b1,2'd1,40'h0,32'h0000_2027,32'h5555_5005,2'd0},
    '{32'h0140_0000,1'b1,1'b0,32'h0000_2005,32'h1111_1007,1'b1,2'd1,40'h0,32'h0000_2005,32'h1111_1007,2'd0},
    '{32'h0180_0000,1'b0,1'b1,32'h0000_2003,32'h2222_2007,1'b1,2'd2,40'h0,32'h0000_2003,32'h2222_2007,2'd0},
    '{32'h01C0_4000,1'b0,1'b1,32'h0000_2027,32'h7777_7003,1'b1,2'd2,40'h0,32'h0000_2027,32'h7777_7003,2'd0},
    '{32'h0200_1234,1'b0,1'b0,32'hFFD4_A087,32'h3333_3007,1'b0,2'd0,40'hA5_FFC0_1234,32'hFFD4_A0A7,32'h3333_3007,2'd1},
    '{32'h0A3F_FFFF,1'b1,1'b0,32'h0240_20A7,32'h4444_4007,1'b0,2'd0,40'h01_027F_FFFF,32'h0240_20E7,32'h4444_4007,2'd1},
    '{32'h0240_0000,1'b0,1'b0,32'h0020_0087,32'h6666_6007,1'b1,2'd3,40'h0,32'h0020_0087,32'h6666_6007,2'd0},
    '{32'h0280_0010,1'b1,1'b0,32'h0C00_00E7,32'h8888_8007,1'b0,2'd0,40'h00_0C00_0010,32'h0C00_00E7,32'h8888_8007,2'd0},
    '{32'h02C0_0000,1'b1,1'b1,32'h0020_0086,32'h9999_9007,1'b1,2'd0,40'h0,32'h0020_0086,32'h9999_9007,2'd0},
    '{32'h0300_5000,1'b1,1'b1,32'h0000_2027,32'hAAAA_A001,1'b1,2'd1,40'h0,32'h0000_2027,32'hAAAA_A001,2'd0},
    '{32'h0340_0000,1'b1,1'b1,32'h0020_0081,32'hBBBB_B007,1'b1,2'd3,40'h0,32'h0020_0081,32'hBBBB_B007,2'd0}
  };

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic preload(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    pl_en = 1'b1; pl_addr = a; pl_data = d;
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  logic        w_flt;
  logic [1:0]  w_cause;
  logic [39:0] w_pa;
  int          w_nwr;
  logic [31:0] w_dir_addr;

  task automatic walk(input logic [31:0] va, input logic wr, input logic usr, input int hold);
    int wc0;
    bit seen;
    seen = 1'b0;
    @(negedge clk);
    wc0 = wcount;
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) begin
      if (mem_req && mem_ack && !mem_we && !seen) begin
        w_dir_addr = mem_addr;
        seen = 1'b1;
      end
      @(negedge clk);
    end
    w_flt = rsp_fault; w_cause = rsp_cause; w_pa = rsp_paddr;
    w_nwr = wcount - wc0;
    for (int h = 0; h < hold; h++) begin
      req_valid = 1'b1; req_vaddr = 32'h0040_3000;
      @(negedge clk);
      chk(rsp_valid === 1'b1 && rsp_paddr === w_pa && rsp_fault === w_flt,
          "R10 response held", {63'd0, rsp_valid}, 64'd1);
      chk(req_ready === 1'b0, "R10 no accept while busy", {63'd0, req_ready}, 64'd0);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req === 1'b0,
        "R11 idle in reset", {61'd0, req_ready, rsp_valid, mem_req}, 64'h4);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req === 1'b0,
        "R11 idle after reset", {61'd0, req_ready, rsp_valid, mem_req}, 64'h4);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] da, ta;
      vec_t v;
      v  = VECS[i];
      da = 32'h1000 + {20'd0, v.va[31:22], 2'b00};
      ta = 32'h2000 + {20'd0, v.va[21:12], 2'b00};
      preload(da, v.pde);
      preload(ta, v.pte);
      walk(v.va, v.wr, v.usr, 0);
      // R1 directory read address, root low bits ignored
      chk(w_dir_addr === da, $sformatf("R1 dir addr v%0d", i), {32'd0, w_dir_addr}, {32'd0, da});
      // R2 R3 R4 R6 fault and cause
      chk(w_flt === v.flt, $sformatf("R2 R3 R4 R6 fault v%0d", i), {63'd0, w_flt}, {63'd0, v.flt});
      if (v.flt)
        chk(w_cause === v.cause, $sformatf("R2 R3 R4 R6 cause v%0d", i), {62'd0, w_cause}, {62'd0, v.cause});
      else
        chk(w_pa === v.pa, $sformatf("R5 R7 paddr v%0d", i), {24'd0, w_pa}, {24'd0, v.pa});
      // R8 flags in memory, R9 write count before response
      chk(mem[da[13:2]] === v.pde_x, $sformatf("R8 dir entry v%0d", i), {32'd0, mem[da[13:2]]}, {32'd0, v.pde_x});
      chk(mem[ta[13:2]] === v.pte_x, $sformatf("R8 table entry v%0d", i), {32'd0, mem[ta[13:2]]}, {32'd0, v.pte_x});
      chk(w_nwr == int'(v.nwr), $sformatf("R9 writes done v%0d", i), 64'(w_nwr), {62'd0, v.nwr});
    end

    // R10 back-pressure on the response, R1 different root base
    root_ctrl = 32'h0000_1123;
    preload(32'h1000 + 32'h4, 32'h0000_2007);
    preload(32'h2000 + 32'hC, 32'h0123_4007);
    walk(32'h0040_3ABC, 1'b1, 1'b0, 4);
    chk(w_pa === 40'h00_0123_4ABC, "R7 paddr after hold", {24'd0, w_pa}, 64'h0123_4ABC);
    chk(mem[(32'h200C) >> 2] === 32'h0123_4067, "R8 dirty on write leaf",
        {32'd0, mem[(32'h200C) >> 2]}, 64'h0123_4067);
    chk(w_nwr == 2, "R9 two write-backs", 64'(w_nwr), 64'd2);
    repeat (2) @(negedge clk);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R10 idle after take",
        {62'd0, req_ready, rsp_valid}, 64'h2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule